// File: doc/BRIEF.md
# Port Pin Interrupt Capture

This block turns the eight pins of a general-purpose input port into eight interrupt request lines for a system interrupt controller. Every clock it registers the port value. A pin that was low in the previous sample and is high now has made a rising edge, and that edge is held in a sticky per-pin latch. A falling pin leaves the latch alone, so a press and a release are separate events and only the press is latched.

For each pin, a mode bit chooses what drives its request. When the bit is 1 the latched edge drives it. When it is 0 the registered pin level drives it. The chosen term is then gated by that pin's enable bit. The eight requests are also placed into a 32-bit pending word at bits 8 to 15, ready to be merged into the controller's pending vector.

Software reaches the block through a small strobed register port. It can clear latched edges by writing ones, program the mode and enable masks, and read back the latches, the masks and the registered pin level.

Top module: `port_irq_capture`

## Requirements
- R1: After reset, the edge latches, the mode mask, the enable mask, the previous-sample register and `rd_data` are all 0, so `irq_req` and `pend_word` are 0.
- R2: Bit i of the edge latch is set by the clock edge at which `pin_in[i]` is 1 and the previous sample of that pin is 0. A 1-to-0 change never sets it.
- R3: A set edge-latch bit stays set until software clears it, whatever the pin does afterwards.
- R4: A write with `wr_en`=1 to address 0 clears every edge-latch bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R5: If a clear of bit i and a new rising edge on pin i fall on the same clock edge, the bit ends up set.
- R6: When mode bit i is 1, request i follows edge-latch bit i. When it is 0, request i follows the pin value registered at the previous clock edge. The mode mask is at address 1.
- R7: Request i is 0 whenever enable bit i is 0. The enable mask is at address 2.
- R8: `pend_word[15:8]` equals `irq_req[7:0]`, with pin 0 at bit 8. All other bits of `pend_word` are 0.
- R9: A clock edge with `rd_en`=1 loads `rd_data` from the selected address: 0 gives the edge latches, 1 the mode mask, 2 the enable mask, 3 the registered pin level. Without `rd_en`, `rd_data` holds its value. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Port pin data, already synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 edge latch (write 1 to clear), 1 mode, 2 enable, 3 level (read only) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, loaded on the clock edge that sees rd_en |
| irq_req | output | 8 | Per-pin interrupt requests |
| pend_word | output | 32 | Requests placed at bits 8 to 15 of a pending word |

## Verification
A corrupted edge latch is visible on the next cycle. It shows on `irq_req` for any enabled pin in edge mode, and it shows in an address-0 read. A latch that drops a bit, or that sets on a falling edge, appears one clock after the pin event, which is why the stimulus sequence mixes presses, releases and clears on neighbouring cycles. A wrong previous-sample register shows up as a level-mode request that lags or leads the pin by a cycle, and as a missing or extra latched edge on the next rising transition.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_EDGE  = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_ENA   = 2'd2,
    SEL_LEVEL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_q,
  output logic [W-1:0] rise_o
);
  function automatic logic [W-1:0] rising(input logic [W-1:0] now_v,
                                          input logic [W-1:0] before_v);
    return now_v & ~before_v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= pin_i;
  end

  assign rise_o = rising(pin_i, level_q);
endmodule

// File: rtl/edge_latch.sv
module edge_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] edge_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) edge_q[i] <= 1'b0;
      else        edge_q[i] <= rise_i[i] | (edge_q[i] & ~clr_i[i]);
    end
  end

  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & $past(rise_i)) == $past(rise_i)));

  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_q) & ~edge_q) & ~$past(clr_i)) == '0));

  p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & $past(clr_i) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/req_merge.sv
module req_merge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] ena_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] req_o
);
  function automatic logic [W-1:0] pick(input logic [W-1:0] m,
                                        input logic [W-1:0] e,
                                        input logic [W-1:0] l);
    return (m & e) | (~m & l);
  endfunction

  logic [W-1:0] chosen;
  assign chosen = pick(mode_i, edge_i, level_i);

  for (genvar i = 0; i < W; i++) begin : g_gate
    assign req_o[i] = chosen[i] & ena_i[i];
  end

  p_req_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~ena_i) == '0);

  p_req_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_o & mode_i) & ~edge_i) == '0);
endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
  import pinirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [W-1:0]          wr_data,
  input  logic [W-1:0]          edge_i,
  input  logic [W-1:0]          level_i,
  output logic [W-1:0]          mode_q,
  output logic [W-1:0]          ena_q,
  output logic [W-1:0]          clr_o,
  output logic [W-1:0]          rd_data
);
  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel   = reg_sel_e'(addr);
  assign clr_o = (wr_en && sel == SEL_EDGE) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ena_q  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MODE) mode_q <= wr_data;
      if (sel == SEL_ENA)  ena_q  <= wr_data;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_EDGE:  rd_mux = edge_i;
      SEL_MODE:  rd_mux = mode_q;
      SEL_ENA:   rd_mux = ena_q;
      SEL_LEVEL: rd_mux = level_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/port_irq_capture.sv
module port_irq_capture
  import pinirq_pkg::*;
#(
  parameter int PIN_W    = 8,
  parameter int PEND_W   = 32,
  parameter int PEND_LSB = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIN_W-1:0]      pin_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]      wr_data,
  output logic [PIN_W-1:0]      rd_data,
  output logic [PIN_W-1:0]      irq_req,
  output logic [PEND_W-1:0]     pend_word
);
  localparam int PEND_MSB = PEND_LSB + PIN_W - 1;

  logic [PIN_W-1:0] level_q, rise_w, edge_q, clr_w, mode_q, ena_q;

  pin_sampler #(.W(PIN_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .level_q(level_q), .rise_o(rise_w)
  );

  edge_latch #(.W(PIN_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .clr_i(clr_w), .edge_q(edge_q)
  );

  pin_cfg_regs #(.W(PIN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .edge_i(edge_q), .level_i(level_q),
    .mode_q(mode_q), .ena_q(ena_q), .clr_o(clr_w), .rd_data(rd_data)
  );

  req_merge #(.W(PIN_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .ena_i(ena_q),
    .edge_i(edge_q), .level_i(level_q), .req_o(irq_req)
  );

  for (genvar b = 0; b < PEND_W; b++) begin : g_pend
    if (b >= PEND_LSB && b <= PEND_MSB) begin : g_live
      assign pend_word[b] = irq_req[b-PEND_LSB];
    end else begin : g_zero
      assign pend_word[b] = 1'b0;
    end
  end

  p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_req & ~mode_q & ena_q) == ($past(pin_in) & ~mode_q & ena_q)));
endmodule

// File: tb/tb_port_irq_capture.sv
module tb_port_irq_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data, irq_req;
  logic [31:0] pend_word;
  int checks = 0, bad = 0;

  always #2 clk = ~clk;

  port_irq_capture dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req),
    .pend_word(pend_word)
  );

  // pin value, clear mask written to address 0, expected requests
  // with mode = 8'hF0 and enable = 8'hFF
  localparam logic [23:0] VEC [10] = '{
    {8'h00, 8'h00, 8'h00},
    {8'h11, 8'h00, 8'h11},
    {8'h00, 8'h00, 8'h10},
    {8'h22, 8'h00, 8'h32},
    {8'h22, 8'h10, 8'h22},
    {8'h20, 8'h20, 8'h00},
    {8'h60, 8'h40, 8'h40},
    {8'h80, 8'h03, 8'hC0},
    {8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [7:0] p, input logic w, input logic r,
                      input logic [1:0] a, input logic [7:0] d);
    pin_in = p; wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {24'd0, irq_req}, 32'h0);
    check("R1 pend", pend_word, 32'h0);
    check("R1 rdata", {24'd0, rd_data}, 32'h0);
    step(8'h00, 1'b0, 1'b1, 2'd1, 8'h00);
    check("R1 mode", {24'd0, rd_data}, 32'h0);
    step(8'h00, 1'b0, 1'b1, 2'd2, 8'h00);
    check("R1 enable", {24'd0, rd_data}, 32'h0);

    step(8'h00, 1'b1, 1'b0, 2'd1, 8'hF0);
    step(8'h00, 1'b1, 1'b0, 2'd2, 8'hFF);
    // R2 R3 R4 R5 R6 stimulus table
    for (int k = 0; k < 10; k++) begin
      step(VEC[k][23:16], VEC[k][15:8] != 8'h00, 1'b0, 2'd0, VEC[k][15:8]);
      check($sformatf("R6 R2 R3 R4 R5 row %0d", k), {24'd0, irq_req}, {24'd0, VEC[k][7:0]});
    end

    // R7 enable gating and R8 pending word
    step(8'h00, 1'b1, 1'b0, 2'd2, 8'h5A);
    step(8'hFF, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R7 gated", {24'd0, irq_req}, 32'h5A);
    check("R8 pend", pend_word, 32'h00005A00);

    // R9 readback
    step(8'hFF, 1'b0, 1'b1, 2'd0, 8'h00);
    check("R9 read edge", {24'd0, rd_data}, 32'hFF);
    step(8'hFF, 1'b0, 1'b1, 2'd1, 8'h00);
    check("R9 read mode", {24'd0, rd_data}, 32'hF0);
    step(8'hFF, 1'b0, 1'b1, 2'd2, 8'h00);
    check("R9 read enable", {24'd0, rd_data}, 32'h5A);
    step(8'hFF, 1'b1, 1'b0, 2'd3, 8'h00);
    check("R9 no read holds", {24'd0, rd_data}, 32'h5A);
    step(8'hFF, 1'b0, 1'b1, 2'd3, 8'h00);
    check("R9 level ignores write", {24'd0, rd_data}, 32'hFF);

    // R6 level mode, then R3 latch survives pin drop and mode switch
    step(8'hFF, 1'b1, 1'b0, 2'd1, 8'h00);
    check("R6 level mode high", {24'd0, irq_req}, 32'h5A);
    step(8'h00, 1'b0, 1'b0, 2'd0, 8'h00);
    check("R6 level mode low", {24'd0, irq_req}, 32'h00);
    step(8'h00, 1'b1, 1'b0, 2'd1, 8'hFF);
    check("R3 latch kept", {24'd0, irq_req}, 32'h5A);

    // R2 falling edge does not latch
    step(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF);
    check("R4 all cleared", {24'd0, irq_req}, 32'h00);
    step(8'h0F, 1'b0, 1'b0, 2'd0, 8'h00);
    step(8'h0F, 1'b1, 1'b0, 2'd0, 8'h0F);
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'h00);
    check("R2 fall no latch", {24'd0, rd_data}, 32'h00);
    step(8'h00, 1'b0, 1'b1, 2'd0, 8'h00);
    check("R2 fall no latch later", {24'd0, rd_data}, 32'h00);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule